// File: doc/BRIEF.md
# Run-Mode Clock Source Selector

This block picks the device clock from three oscillators: a primary oscillator, an internal oscillator and a low-power secondary oscillator. It changes from one source to another without glitches. Each source has its own enable stage. The enable of the outgoing source drops through a two-flop synchronizer in that source's domain. Only after that drop does the incoming source's enable rise through its own two-flop synchronizer. Three status flags report which source drives the clock. A busy output stays high from the moment a new selection is seen until the handover is complete.

A switch does not start until the requested source reports ready. The outgoing source keeps clocking the core and the peripherals while it waits. When the secondary oscillator is selected or has been enabled on its own, the block asks for it to run, and it keeps it running after a later return to the primary source. When the primary source is wanted again, the block asks for the primary oscillator to restart.

A sleep request samples an idle-enable bit. With the bit clear, the core clock and the peripheral clock both stop. With the bit set, only the core clock stops. A wake input restores both clocks. Both outputs are gated by latch-based enables that change only while the source clock is low. A parameter lets the internal oscillator act as the primary source, and in that case the primary and internal flags may be set together.

Top module: `clk_src_switch`

## Requirements
- R1: After reset the primary source drives both clocks, the flags {stat_sec, stat_int, stat_pri} read 001, busy is 0, pri_on is 1 and sosc_on is 0.
- R2: src_sel 00 selects the primary source, 01 the secondary and 10 or 11 the internal one. Once settled, the flags read 001 for primary, 100 for secondary and 010 for internal with int_rdy high. They read 000 while the internal source drives the clock with int_rdy low.
- R3: A switch waits until the requested source's ready input is high. Meanwhile the previous source keeps driving the clocks and busy stays 1.
- R4: When the target is ready, the outgoing source gives at least two more full cycles after src_sel is written. The incoming source appears within 4 outgoing plus 4 incoming periods of the write.
- R5: Every high phase on clk_per is exactly one full high phase of one of the three sources. No pulse is shortened.
- R6: sosc_on is high while sosc_en is high or the secondary source is selected. It stays high after the secondary source has been active, until reset. If sosc_en has already brought the secondary oscillator up, a switch to it does not wait for start-up.
- R7: On a return from secondary to primary, pri_on rises while the clocks stay on the secondary source. The switch completes only after pri_rdy, and then the flags read 001.
- R8: A rising sleep_req with idle_en 0 stops both clk_core and clk_per. With idle_en 1 it stops clk_core only. A further request re-samples idle_en.
- R9: A high wake input while clocks are stopped restarts both clk_core and clk_per.
- R10: A selection written while a switch is in progress is held. It is carried out after the current switch completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset |
| clk_pri | input | 1 | Primary oscillator clock |
| clk_int | input | 1 | Internal oscillator clock |
| clk_sec | input | 1 | Secondary oscillator clock |
| pri_rdy | input | 1 | Primary oscillator stable |
| int_rdy | input | 1 | Internal oscillator stable |
| sec_rdy | input | 1 | Secondary oscillator stable |
| src_sel | input | 2 | Source selection |
| sosc_en | input | 1 | Keep the secondary oscillator running |
| sleep_req | input | 1 | Power-down request, rising edge |
| idle_en | input | 1 | 1: idle on request, 0: sleep |
| wake | input | 1 | Wake-up event |
| clk_core | output | 1 | Gated core clock |
| clk_per | output | 1 | Gated peripheral clock |
| stat_pri | output | 1 | Primary source active |
| stat_int | output | 1 | Internal source active and stable |
| stat_sec | output | 1 | Secondary source active |
| busy | output | 1 | Switch pending or in progress |
| pri_on | output | 1 | Request to run the primary oscillator |
| sosc_on | output | 1 | Request to run the secondary oscillator |

## Verification
The assertions assume that all three source clocks toggle freely, including during reset. They assume that a ready input only rises once its oscillator is actually stable. They also assume that sleep_req and wake stay high for at least two cycles of the slowest clock that could be driving the block. The bench models each oscillator with a fixed start-up delay after its run request, and drives select writes between clock edges. It holds each sleep and wake pulse for 150 ns, which covers the two-flop synchronizers even when the slow secondary clock is in use.

// File: rtl/csw_pkg.sv
package csw_pkg;

    localparam int NSRC    = 3;
    localparam int SRC_PRI = 0;
    localparam int SRC_INT = 1;
    localparam int SRC_SEC = 2;

    typedef logic [NSRC-1:0] srcvec_t;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_SLEEP = 2'd2
    } pmode_e;

    typedef struct packed {
        logic sec_run;
        logic int_ok;
        logic pri_act;
    } stat_t;

    // 00 primary, 01 secondary, 1x internal
    function automatic srcvec_t decode_sel(input logic [1:0] s);
        case (s)
            2'b00:   return srcvec_t'(1) << SRC_PRI;
            2'b01:   return srcvec_t'(1) << SRC_SEC;
            default: return srcvec_t'(1) << SRC_INT;
        endcase
    endfunction

    function automatic pmode_e mode_after_req(input logic idle);
        return idle ? MODE_IDLE : MODE_SLEEP;
    endfunction

endpackage

// File: rtl/csw_sync.sv
module csw_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/csw_src_slice.sv
module csw_src_slice #(
    parameter logic RESET_ON = 1'b0
) (
    input  logic clk_src,
    input  logic rst,
    input  logic req,
    output logic en,
    output logic gclk
);
    logic req_s;

    csw_sync #(.W(1), .RST_VAL(RESET_ON)) u_sync (
        .clk (clk_src),
        .rst (rst),
        .d   (req),
        .q   (req_s)
    );

    // enable moves only while the source is low
    always_ff @(negedge clk_src) begin
        if (rst) en <= RESET_ON;
        else     en <= req_s;
    end

    assign gclk = clk_src & en;
endmodule

// File: rtl/csw_src_mux.sv
module csw_src_mux
    import csw_pkg::*;
#(
    parameter int RESET_SRC = SRC_PRI
) (
    input  srcvec_t clk_src,
    input  logic    rst,
    input  srcvec_t want,
    output srcvec_t en,
    output logic    clk_out
);
    srcvec_t gclk;

    for (genvar i = 0; i < NSRC; i++) begin : g_slice
        srcvec_t others;
        logic    req;
        assign others = en & ~(srcvec_t'(1) << i);
        assign req    = want[i] & ~(|others);

        csw_src_slice #(.RESET_ON(i == RESET_SRC)) u_slice (
            .clk_src (clk_src[i]),
            .rst     (rst),
            .req     (req),
            .en      (en[i]),
            .gclk    (gclk[i])
        );
    end

    assign clk_out = |gclk;
endmodule

// File: rtl/csw_clk_gate.sv
module csw_clk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_l;

    always_latch begin
        if (!clk) en_l = en;
    end

    assign gclk = clk & en_l;
endmodule

// File: rtl/csw_ctrl.sv
module csw_ctrl
    import csw_pkg::*;
#(
    parameter logic PRI_IS_INT = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  srcvec_t    en_raw,
    input  srcvec_t    rdy_raw,
    input  logic [1:0] src_sel,
    input  logic       sosc_en,
    input  logic       sleep_req,
    input  logic       idle_en,
    input  logic       wake,
    output srcvec_t    want,
    output stat_t      stat,
    output logic       busy,
    output logic       pri_on,
    output logic       sosc_on,
    output logic       core_en,
    output logic       per_en
);
    localparam srcvec_t RESET_VEC = srcvec_t'(1) << SRC_PRI;

    logic [1:0] sel_q;
    srcvec_t    dsel, act_q, rdy_s;
    logic       settled, tgt_ok, keep_q;
    logic [2:0] pm_s;
    logic       sreq_prev, sreq_rise;
    pmode_e     mode_q, mode_d;

    always_ff @(posedge clk) begin
        if (rst) sel_q <= 2'b00;
        else     sel_q <= src_sel;
    end

    assign dsel = decode_sel(sel_q);

    csw_sync #(.W(NSRC), .RST_VAL(RESET_VEC)) u_act (
        .clk (clk), .rst (rst), .d (en_raw), .q (act_q)
    );

    csw_sync #(.W(NSRC), .RST_VAL('0)) u_rdy (
        .clk (clk), .rst (rst), .d (rdy_raw), .q (rdy_s)
    );

    csw_sync #(.W(3), .RST_VAL('0)) u_pm (
        .clk (clk), .rst (rst), .d ({wake, idle_en, sleep_req}), .q (pm_s)
    );

    assign settled = (act_q == want);
    assign tgt_ok  = |(dsel & rdy_s);

    always_ff @(posedge clk) begin
        if (rst)                                     want <= RESET_VEC;
        else if (settled && dsel != want && tgt_ok)  want <= dsel;
    end

    always_ff @(posedge clk) begin
        if (rst)                 keep_q <= 1'b0;
        else if (act_q[SRC_SEC]) keep_q <= 1'b1;
    end

    assign busy    = !settled || (dsel != want);
    assign sosc_on = sosc_en | keep_q | dsel[SRC_SEC] | want[SRC_SEC];
    assign pri_on  = dsel[SRC_PRI] | want[SRC_PRI] | act_q[SRC_PRI];

    assign stat.pri_act = act_q[SRC_PRI];
    assign stat.int_ok  = rdy_s[SRC_INT] &
                          (act_q[SRC_INT] | (PRI_IS_INT & act_q[SRC_PRI]));
    assign stat.sec_run = act_q[SRC_SEC];

    // power mode: bit 0 request, bit 1 idle select, bit 2 wake
    assign sreq_rise = pm_s[0] & ~sreq_prev;

    always_comb begin
        mode_d = mode_q;
        if (mode_q != MODE_RUN && pm_s[2]) mode_d = MODE_RUN;
        else if (sreq_rise)                mode_d = mode_after_req(pm_s[1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_RUN;
            sreq_prev <= 1'b0;
        end else begin
            mode_q    <= mode_d;
            sreq_prev <= pm_s[0];
        end
    end

    assign core_en = (mode_q == MODE_RUN);
    assign per_en  = (mode_q != MODE_SLEEP);

    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(en_raw));                                              // R5
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(stat.sec_run && (stat.pri_act || stat.int_ok)));              // R2
    AST_TAKE_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        (want != $past(want)) |-> |(want & $past(rdy_s)));             // R3
    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (want != $past(want)) |-> $past(act_q == want));               // R10
    AST_SLEEP_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MODE_RUN && $past(mode_q) == MODE_RUN) |-> $past(sreq_rise)); // R8
    AST_SOSC_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(keep_q) |-> sosc_on);                                     // R6
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
    import csw_pkg::*;
#(
    parameter logic PRI_IS_INT = 1'b0
) (
    input  logic       rst,
    input  logic       clk_pri,
    input  logic       clk_int,
    input  logic       clk_sec,
    input  logic       pri_rdy,
    input  logic       int_rdy,
    input  logic       sec_rdy,
    input  logic [1:0] src_sel,
    input  logic       sosc_en,
    input  logic       sleep_req,
    input  logic       idle_en,
    input  logic       wake,
    output logic       clk_core,
    output logic       clk_per,
    output logic       stat_pri,
    output logic       stat_int,
    output logic       stat_sec,
    output logic       busy,
    output logic       pri_on,
    output logic       sosc_on
);
    srcvec_t    clk_vec, rdy_vec, en, want;
    logic       clk_sys;
    stat_t      st;
    logic [1:0] gate_en, gate_out;

    assign clk_vec[SRC_PRI] = clk_pri;
    assign clk_vec[SRC_INT] = clk_int;
    assign clk_vec[SRC_SEC] = clk_sec;
    assign rdy_vec[SRC_PRI] = pri_rdy;
    assign rdy_vec[SRC_INT] = int_rdy;
    assign rdy_vec[SRC_SEC] = sec_rdy;

    csw_src_mux #(.RESET_SRC(SRC_PRI)) u_mux (
        .clk_src (clk_vec),
        .rst     (rst),
        .want    (want),
        .en      (en),
        .clk_out (clk_sys)
    );

    csw_ctrl #(.PRI_IS_INT(PRI_IS_INT)) u_ctrl (
        .clk       (clk_sys),
        .rst       (rst),
        .en_raw    (en),
        .rdy_raw   (rdy_vec),
        .src_sel   (src_sel),
        .sosc_en   (sosc_en),
        .sleep_req (sleep_req),
        .idle_en   (idle_en),
        .wake      (wake),
        .want      (want),
        .stat      (st),
        .busy      (busy),
        .pri_on    (pri_on),
        .sosc_on   (sosc_on),
        .core_en   (gate_en[0]),
        .per_en    (gate_en[1])
    );

    for (genvar g = 0; g < 2; g++) begin : g_gate
        csw_clk_gate u_gate (
            .clk  (clk_sys),
            .en   (gate_en[g]),
            .gclk (gate_out[g])
        );
    end

    assign clk_core = gate_out[0];
    assign clk_per  = gate_out[1];
    assign stat_pri = st.pri_act;
    assign stat_int = st.int_ok;
    assign stat_sec = st.sec_run;
endmodule

// File: tb/test_clk_src_switch.sv
`timescale 1ns/100ps
module test_clk_src_switch;
    localparam int CLK_PERIOD = 10;
    localparam int INT_PERIOD = 14;
    localparam int SEC_PERIOD = 46;
    localparam int WD_NS      = 1_500_000;

    logic       rst = 1'b1;
    logic       clk_pri, clk_int, clk_sec;
    logic       pri_rdy = 1'b1;
    logic       int_rdy = 1'b1;
    logic       sec_rdy = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic       sosc_en = 1'b0, sleep_req = 1'b0, idle_en = 1'b0, wake = 1'b0;
    logic       clk_core, clk_per, stat_pri, stat_int, stat_sec, busy, pri_on, sosc_on;

    clk_src_switch i_clk_src_switch (
        .rst(rst), .clk_pri(clk_pri), .clk_int(clk_int), .clk_sec(clk_sec),
        .pri_rdy(pri_rdy), .int_rdy(int_rdy), .sec_rdy(sec_rdy),
        .src_sel(src_sel), .sosc_en(sosc_en), .sleep_req(sleep_req),
        .idle_en(idle_en), .wake(wake), .clk_core(clk_core), .clk_per(clk_per),
        .stat_pri(stat_pri), .stat_int(stat_int), .stat_sec(stat_sec),
        .busy(busy), .pri_on(pri_on), .sosc_on(sosc_on)
    );

    initial begin clk_pri = 0; forever #(CLK_PERIOD/2) clk_pri = ~clk_pri; end
    initial begin clk_int = 0; #0.2; forever #(INT_PERIOD/2) clk_int = ~clk_int; end
    initial begin clk_sec = 0; #0.4; forever #(SEC_PERIOD/2) clk_sec = ~clk_sec; end

    // oscillator start-up models
    always @(pri_on) begin
        if (!pri_on) pri_rdy = 1'b0;
        else begin #200; if (pri_on) pri_rdy = 1'b1; end
    end
    always @(sosc_on) begin
        if (!sosc_on) sec_rdy = 1'b0;
        else begin #300; if (sosc_on) sec_rdy = 1'b1; end
    end

    function automatic int period_of(input int k);
        return (k == 0) ? CLK_PERIOD : (k == 1) ? INT_PERIOD : SEC_PERIOD;
    endfunction
    function automatic int kind_of_width(input real w);
        for (int k = 0; k < 3; k++) begin
            real d;
            d = w - period_of(k) / 2.0;
            if (d < 0.05 && d > -0.05) return k;
        end
        return -1;
    endfunction
    function automatic int exp_kind(input logic [1:0] s);
        return (s == 2'b00) ? 0 : (s == 2'b01) ? 2 : 1;
    endfunction
    function automatic logic [2:0] exp_flags(input logic [1:0] s, input logic iok);
        case (s)
            2'b00:   return 3'b001;
            2'b01:   return 3'b100;
            default: return iok ? 3'b010 : 3'b000;
        endcase
    endfunction

    // clk_per pulse monitor
    real t_rise = -1.0;
    real mark_t = 1.0e12;
    real first_mark [3] = '{-1.0, -1.0, -1.0};
    real first_t    [3] = '{0.0, 0.0, 0.0};
    int  cnt_after  [3] = '{0, 0, 0};
    int  glitch_n = 0, per_n = 0, core_n = 0, last_k = -1;

    always @(posedge clk_per) begin t_rise = $realtime; per_n++; end
    always @(posedge clk_core) core_n++;
    always @(negedge clk_per) begin : mon
        int k;
        if (t_rise >= 0.0) begin
            k = kind_of_width($realtime - t_rise);
            if (k < 0) glitch_n++;
            else begin
                last_k = k;
                if (t_rise >= mark_t) begin
                    if (first_mark[k] != mark_t) begin
                        first_mark[k] = mark_t; first_t[k] = t_rise; cnt_after[k] = 1;
                    end else cnt_after[k]++;
                end
            end
        end
    end

    int n_chk = 0, n_bad = 0, glitch_base = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic settle(input string req);
        int polls = 0;
        #60;
        while (busy && polls < 20000) begin #1; polls++; end
        chk(!busy, req, "switch settles", busy, 0);
        #150;
    endtask

    function automatic logic [2:0] flags();
        return {stat_sec, stat_int, stat_pri};
    endfunction

    task automatic do_reset();
        rst = 1'b1; src_sel = 2'b00; sleep_req = 0; wake = 0; idle_en = 0;
        #300; rst = 1'b0; #200;
        glitch_base = glitch_n;
    endtask

    task automatic do_switch(input logic [1:0] s, input string req, input bit timed);
        int  oldk, newk;
        real ts;
        oldk = last_k; newk = exp_kind(s);
        mark_t = $realtime; ts = $realtime; src_sel = s;
        settle(req);
        chk(flags() == exp_flags(s, int_rdy), req, "flags after switch", flags(), exp_flags(s, int_rdy));
        chk(last_k == newk, req, "source on clk_per", last_k, newk);
        chk(glitch_n == glitch_base, "R5", "short pulses", glitch_n, glitch_base);
        if (timed && oldk != newk && oldk >= 0) begin
            chk(first_mark[oldk] == mark_t && cnt_after[oldk] >= 2, "R4",
                "outgoing cycles after write", cnt_after[oldk], 2);
            chk(first_mark[newk] == mark_t &&
                (first_t[newk] - ts) <= 4.0 * (period_of(oldk) + period_of(newk)), "R4",
                "incoming latency ns", $rtoi(first_t[newk] - ts),
                4 * (period_of(oldk) + period_of(newk)));
        end
    endtask

    task automatic pulse_sleep(input logic idle);
        idle_en = idle; #20; sleep_req = 1; #150; sleep_req = 0; #200;
    endtask

    task automatic window(output int dc, output int dp);
        int c0, p0;
        c0 = core_n; p0 = per_n; #300;
        dc = core_n - c0; dp = per_n - p0;
    endtask

    task automatic run_all();
        int  dc, dp;
        real ts;
        #0.3;
        void'($urandom(32'd2024));
        do_reset();
        // R1 reset state
        chk(flags() == 3'b001, "R1", "flags", flags(), 3'b001);
        chk(busy == 0, "R1", "busy", busy, 0);
        chk(pri_on == 1 && sosc_on == 0, "R1", "osc requests", {pri_on, sosc_on}, 2'b10);
        window(dc, dp);
        chk(dc > 0 && dp > 0 && last_k == 0, "R1", "clocks on primary", last_k, 0);

        // primary -> internal
        do_switch(2'b11, "R2", 1'b1);
        // internal not yet stable
        int_rdy = 0; #200;
        chk(flags() == 3'b000, "R2", "flags internal unstable", flags(), 3'b000);
        chk(last_k == 1, "R2", "still internal clock", last_k, 1);
        int_rdy = 1; #200;
        chk(flags() == 3'b010, "R2", "flags internal stable", flags(), 3'b010);

        // internal -> secondary, oscillator cold
        mark_t = $realtime; ts = $realtime; src_sel = 2'b01;
        #150;
        chk(busy == 1, "R3", "busy while waiting", busy, 1);
        chk(last_k == 1, "R3", "old clock keeps running", last_k, 1);
        chk(sosc_on == 1, "R6", "secondary requested", sosc_on, 1);
        settle("R3");
        chk(flags() == 3'b100, "R2", "flags secondary", flags(), 3'b100);
        chk(first_mark[2] == mark_t && (first_t[2] - ts) >= 300.0, "R6",
            "cold start waits ns", $rtoi(first_t[2] - ts), 300);

        // secondary -> primary
        chk(pri_on == 0, "R7", "primary idle in secondary", pri_on, 0);
        src_sel = 2'b00; #120;
        chk(pri_on == 1, "R7", "primary restarted", pri_on, 1);
        chk(stat_sec == 1 && busy == 1 && last_k == 2, "R7", "stays on secondary",
            {stat_sec, busy}, 2'b11);
        settle("R7");
        chk(flags() == 3'b001 && last_k == 0, "R7", "back on primary", flags(), 3'b001);
        chk(sosc_on == 1, "R6", "secondary kept running", sosc_on, 1);

        // power modes
        pulse_sleep(1'b1); window(dc, dp);
        chk(dc == 0, "R8", "idle core pulses", dc, 0);
        chk(dp > 0, "R8", "idle peripheral runs", dp, 1);
        pulse_sleep(1'b0); window(dc, dp);
        chk(dc == 0 && dp == 0, "R8", "resampled sleep pulses", dc + dp, 0);
        wake = 1; #150; wake = 0; #200; window(dc, dp);
        chk(dc > 0 && dp > 0, "R9", "wake restores clocks", dc, 1);
        pulse_sleep(1'b0); window(dc, dp);
        chk(dc == 0 && dp == 0, "R8", "sleep from run", dc + dp, 0);
        wake = 1; #150; wake = 0; #200; window(dc, dp);
        chk(dc > 0 && dp > 0, "R9", "wake from sleep", dp, 1);

        // phase 2: secondary brought up beforehand
        do_reset();
        chk(sosc_on == 0 && flags() == 3'b001, "R1", "second reset", {sosc_on, flags()}, 4'b0001);
        sosc_en = 1; #20;
        chk(sosc_on == 1, "R6", "enable requests secondary", sosc_on, 1);
        #500;
        ts = $realtime;
        do_switch(2'b01, "R6", 1'b1);
        chk(first_mark[2] == mark_t && (first_t[2] - ts) < 300.0, "R6",
            "warm switch ns", $rtoi(first_t[2] - ts), 299);

        // request queued behind a running switch
        mark_t = $realtime; src_sel = 2'b11; #60; src_sel = 2'b00;
        settle("R10");
        chk(flags() == 3'b001, "R10", "final source", flags(), 3'b001);
        chk(first_mark[1] == mark_t, "R10", "held switch ran first", first_mark[1] == mark_t, 1);

        // random sequence
        for (int it = 0; it < 24; it++) begin
            logic [1:0] s;
            s = 2'($urandom % 4);
            sosc_en = 1'($urandom % 2);
            do_switch(s, "R2", !(s == 2'b00 && !pri_rdy));
            chk(sosc_on == 1, "R6", "secondary stays on", sosc_on, 1);
        end
    endtask

    initial begin
        bit timeout = 0;
        fork
            run_all();
            begin #(WD_NS); timeout = 1; end
        join_any
        disable fork;
        if (timeout) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule